// File: doc/BRIEF.md
# Configuration Write CRC Accumulator

This block keeps a running 16-bit CRC over the register writes of a configuration stream. Each accepted write joins the target register address to its 32-bit data word and folds the resulting 37-bit word (36 bits when the address field is 4 bits wide) into the CRC. It processes one bit per clock.

The upstream parser presents one write at a time. It waits for `ready` before presenting the next write, and it pulses `crc_clr` when the stream carries an explicit CRC reset command. At a checkpoint the parser presents an expected value on the check port. Any disagreement with the running CRC raises a sticky `mismatch` flag, which only the next clear command or the hardware reset removes.

Top module: `cfg_crc_accum`

## Requirements
- R1: After `rst_n` is deasserted, `crc_out` is 0x0000, `ready` is 1 and `mismatch` is 0.
- R2: A write is accepted only in a cycle where `wr_valid` and `ready` are both 1 and `crc_clr` is 0. `ready` is then 0 for exactly ADDR_W+32 cycles, starting with the cycle after acceptance.
- R3: The CRC uses polynomial x^16+x^15+x^2+1 (0x8005), MSB-first shift, and no final inversion. For each input bit b, the feedback is crc[15]^b, crc shifts left by one, and 0x8005 is XORed in when the feedback is 1. The bits are fed as `wr_data` bit 0 through bit 31, followed by `wr_addr` bit 0 through its top bit.
- R4: The CRC is not cleared between writes. Each word continues from the value left by the previous word.
- R5: With ADDR_W=4, each word covers 36 bits and `ready` stays low for 36 cycles.
- R6: `crc_clr` sets `crc_out` to 0x0000 and `mismatch` to 0 on the next edge, and it abandons any word in progress, so `ready` is 1 on the next cycle. A write presented in the same cycle as `crc_clr` is dropped.
- R7: `wr_valid` asserted while `ready` is 0 has no effect on the CRC.
- R8: When `chk_valid` is 1 and `ready` is 1, `mismatch` becomes 1 on the next edge if `crc_out` differs from `chk_value`. It is left unchanged if the two are equal.
- R9: Once set, `mismatch` stays 1 until `crc_clr` or `rst_n`.
- R10: `chk_valid` asserted while `ready` is 0 is ignored.
- R11: While `ready` is 1 and no write or clear occurs, `crc_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write present |
| wr_addr | input | ADDR_W | Target register address |
| wr_data | input | 32 | Data word written |
| crc_clr | input | 1 | Stream CRC reset command |
| chk_valid | input | 1 | Compare request |
| chk_value | input | 16 | Expected CRC |
| ready | output | 1 | Idle, able to accept a write |
| crc_out | output | 16 | Running CRC |
| mismatch | output | 1 | Sticky compare failure flag |

## Verification
The bench builds two instances side by side: one with the default 5-bit address field, and one with ADDR_W=4. The default instance covers the 37-cycle framing, clear-versus-write priority, aborts and the compare flag. The 4-bit instance shows that the word length and bit count follow the parameter, giving the 36-cycle busy window and a CRC computed from 36 bits.

// File: rtl/cfg_crc_accum.sv
module cfg_crc_accum #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h8005,
  parameter logic [CRC_W-1:0] INIT = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              crc_clr,
  input  logic              chk_valid,
  input  logic [CRC_W-1:0]  chk_value,
  output logic              ready,
  output logic [CRC_W-1:0]  crc_out,
  output logic              mismatch
);
  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  logic [CRC_W-1:0]  crc_q;
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              mis_q;

  wire             accept = wr_valid && ready && !crc_clr;
  wire             fb     = crc_q[CRC_W-1] ^ sh_q[0];
  wire [CRC_W-1:0] step   = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);

  assign ready    = (cnt_q == '0);
  assign crc_out  = crc_q;
  assign mismatch = mis_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= INIT;
      sh_q  <= '0;
      cnt_q <= '0;
      mis_q <= 1'b0;
    end else if (crc_clr) begin
      crc_q <= INIT;
      cnt_q <= '0;
      mis_q <= 1'b0;
    end else begin
      if (accept) begin
        sh_q  <= {wr_addr, wr_data};
        cnt_q <= CNT_W'(WORD_W);
      end else if (!ready) begin
        crc_q <= step;
        sh_q  <= sh_q >> 1;
        cnt_q <= cnt_q - 1'b1;
      end
      if (chk_valid && ready && (crc_q != chk_value))
        mis_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_crc_accum_chk.sv
module cfg_crc_accum_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CRC_W  = 16,
  parameter logic [CRC_W-1:0] INIT = 16'h0000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             crc_clr,
  input logic             chk_valid,
  input logic [CRC_W-1:0] chk_value,
  input logic             ready,
  input logic [CRC_W-1:0] crc_out,
  input logic             mismatch
);
  localparam int WORD_W = ADDR_W + DATA_W;
  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 0;
    else if (ready) run_q <= 0;
    else run_q <= run_q + 1;
  end

  a_r2_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= WORD_W);
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && ready && !crc_clr |=> !ready);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    crc_clr |=> (crc_out == INIT) && ready && !mismatch);
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && ready && !crc_clr && (crc_out != chk_value) |=> mismatch);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch && !crc_clr |=> mismatch);
  a_r10_busy_check: assert property (@(posedge clk) disable iff (!rst_n)
    !ready && !mismatch && !crc_clr |=> !mismatch);
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !wr_valid && !crc_clr |=> $stable(crc_out));
endmodule

bind cfg_crc_accum cfg_crc_accum_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CRC_W(CRC_W), .INIT(INIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .crc_clr(crc_clr),
  .chk_valid(chk_valid), .chk_value(chk_value), .ready(ready),
  .crc_out(crc_out), .mismatch(mismatch)
);

// File: tb/tb_cfg_crc_accum.sv
module tb_cfg_crc_accum;
  logic clk = 0;
  always #2 clk = ~clk;

  logic rst_n = 0;
  logic wr_valid = 0, crc_clr = 0, chk_valid = 0;
  logic [4:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [15:0] chk_value = 0;
  logic ready, mismatch;
  logic [15:0] crc_out;

  logic b_wr_valid = 0;
  logic [3:0]  b_addr = 0;
  logic [31:0] b_data = 0;
  logic b_ready, b_mismatch;
  logic [15:0] b_crc;

  cfg_crc_accum dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .crc_clr(crc_clr), .chk_valid(chk_valid),
    .chk_value(chk_value), .ready(ready), .crc_out(crc_out), .mismatch(mismatch));

  cfg_crc_accum #(.ADDR_W(4)) dut_b (
    .clk(clk), .rst_n(rst_n), .wr_valid(b_wr_valid), .wr_addr(b_addr),
    .wr_data(b_data), .crc_clr(1'b0), .chk_valid(1'b0),
    .chk_value(16'h0), .ready(b_ready), .crc_out(b_crc), .mismatch(b_mismatch));

  int checks = 0, errors = 0;
  logic [15:0] exp_a = 0;
  bit done = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(logic [15:0] c, logic [4:0] a,
                                        logic [31:0] d, int aw);
    for (int i = 0; i < 32 + aw; i++) begin
      logic b, f;
      b = (i < 32) ? d[i] : a[i-32];
      f = c[15] ^ b;
      c = {c[14:0], 1'b0} ^ (f ? 16'h8005 : 16'h0);
    end
    return c;
  endfunction

  task automatic write_a(logic [4:0] a, logic [31:0] d, output int busy);
    @(negedge clk); wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_valid = 0;
    busy = 0;
    while (!ready && busy < 100) begin busy++; @(negedge clk); end
    exp_a = model(exp_a, a, d, 5);
  endtask

  task automatic t_reset;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1 crc", crc_out, 0);
    check("R1 ready", ready, 1);
    check("R1 mismatch", mismatch, 0);
  endtask

  task automatic t_single;
    int busy;
    write_a(5'h1B, 32'hDEADBEEF, busy);
    check("R2 busy cycles", busy, 37);
    check("R3 crc value", crc_out, exp_a);
  endtask

  task automatic t_running;
    int busy;
    write_a(5'h00, 32'h0000_0000, busy);
    check("R4 after zero word", crc_out, exp_a);
    write_a(5'h1F, 32'hFFFF_FFFF, busy);
    check("R4 after ones word", crc_out, exp_a);
    write_a(5'h10, 32'h0000_0001, busy);
    check("R3 addr top bit", crc_out, exp_a);
  endtask

  task automatic t_idle;
    repeat (6) @(negedge clk);
    check("R11 idle hold", crc_out, exp_a);
  endtask

  task automatic t_busy_write;
    int n = 0;
    @(negedge clk); wr_valid = 1; wr_addr = 5'h05; wr_data = 32'h1234_5678;
    @(negedge clk); wr_addr = 5'h0A; wr_data = 32'hCAFE_F00D;
    repeat (5) @(negedge clk);
    wr_valid = 0;
    while (!ready && n < 100) begin n++; @(negedge clk); end
    exp_a = model(exp_a, 5'h05, 32'h1234_5678, 5);
    check("R7 busy write ignored", crc_out, exp_a);
    check("R7 ready after", ready, 1);
  endtask

  task automatic t_check;
    @(negedge clk); chk_valid = 1; chk_value = exp_a;
    @(negedge clk); chk_valid = 0;
    check("R8 equal no flag", mismatch, 0);
    @(negedge clk); chk_valid = 1; chk_value = exp_a ^ 16'h0001;
    @(negedge clk); chk_valid = 0;
    check("R8 differ sets flag", mismatch, 1);
    begin int busy; write_a(5'h03, 32'h0BAD_F00D, busy); end
    @(negedge clk); chk_valid = 1; chk_value = exp_a;
    @(negedge clk); chk_valid = 0;
    check("R9 sticky", mismatch, 1);
    @(negedge clk); crc_clr = 1;
    @(negedge clk); crc_clr = 0;
    exp_a = 0;
    check("R6 clr crc", crc_out, 0);
    check("R9 clr flag", mismatch, 0);
  endtask

  task automatic t_busy_check;
    int n = 0;
    @(negedge clk); wr_valid = 1; wr_addr = 5'h07; wr_data = 32'hA5A5_5A5A;
    @(negedge clk); wr_valid = 0; chk_valid = 1; chk_value = 16'hFFFF;
    repeat (4) @(negedge clk);
    chk_valid = 0;
    while (!ready && n < 100) begin n++; @(negedge clk); end
    exp_a = model(exp_a, 5'h07, 32'hA5A5_5A5A, 5);
    check("R10 busy check ignored", mismatch, 0);
    check("R10 crc", crc_out, exp_a);
  endtask

  task automatic t_abort;
    @(negedge clk); wr_valid = 1; wr_addr = 5'h11; wr_data = 32'h8765_4321;
    @(negedge clk); wr_valid = 0;
    repeat (10) @(negedge clk);
    check("R6 busy before abort", ready, 0);
    crc_clr = 1;
    @(negedge clk); crc_clr = 0;
    exp_a = 0;
    check("R6 abort ready", ready, 1);
    check("R6 abort crc", crc_out, 0);
    repeat (3) @(negedge clk);
    check("R6 abort stays", crc_out, 0);
  endtask

  task automatic t_clr_write;
    int busy;
    write_a(5'h02, 32'h0F0F_0F0F, busy);
    @(negedge clk); wr_valid = 1; crc_clr = 1; wr_addr = 5'h1C; wr_data = 32'h1111_2222;
    @(negedge clk); wr_valid = 0; crc_clr = 0;
    exp_a = 0;
    check("R6 clr wins ready", ready, 1);
    check("R6 clr wins crc", crc_out, 0);
  endtask

  task automatic t_legacy;
    int n = 0;
    logic [15:0] e;
    @(negedge clk); b_wr_valid = 1; b_addr = 4'h9; b_data = 32'hC0DE_1234;
    @(negedge clk); b_wr_valid = 0;
    while (!b_ready && n < 100) begin n++; @(negedge clk); end
    e = model(16'h0, 5'h09, 32'hC0DE_1234, 4);
    check("R5 busy cycles", n, 36);
    check("R5 crc value", b_crc, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_single;
    t_running;
    t_idle;
    t_busy_write;
    t_check;
    t_busy_check;
    t_abort;
    t_clr_write;
    t_legacy;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule